// File: doc/BRIEF.md
# Four-Channel Memory-to-Memory DMA Engine

The engine copies blocks of elements from one memory location to another on behalf of software. Each of four channels is set up through a 32-bit register port. Software writes a 64-bit source address, a 64-bit destination address and an element count, then writes the channel's control word with the enable bit set. The engine reads one element, writes it back out, and repeats until the count runs out. It then drops the enable bit and raises that channel's done flag.

Memory traffic uses two valid/ready request channels (read request, write) and one valid/ready read-response channel. Back-pressure rules:
- A request that is not yet accepted keeps its valid, address, size and data unchanged until ready is seen high at a clock edge.
- The engine raises `rd_resp_ready` only while it waits for read data. A response is consumed on the edge where both valid and ready are high.

Data travels little-endian. An element occupies the low bytes of the 64-bit data bus, and the byte for the lowest address is in bits 7:0.

Only one channel moves data at a time. An element is fully written before the next read is issued.

Top module: `dma4_engine`

## Requirements
- R1: After reset, every channel register and the status word read as zero.
- R2: Register slot = channel*8 + index. The index order is: control, count, source high, source low, destination high, destination low, descriptor-pointer high, descriptor-pointer low. Every slot reads back the last value written. The status word is at slot 32; bits 3:0 are the per-channel done flags and bit 8 is busy.
- R3: Writing one 32-bit half of a 64-bit address leaves the other half unchanged.
- R4: Writing a control word with bit 31 set starts the channel. The channel moves exactly as many elements as bits 15:0 of its count register; bits 31:16 of that register are ignored.
- R5: Control bits 26:25 hold a width code w, and the element size is 2^w bytes. Read and write beats carry w on their size field. Data is little-endian, with the byte at the lowest address in bits 7:0 and unused upper bytes driven to zero.
- R6: Control bit 23 lets the source address step and bit 24 lets the destination address step, each by the element size. When a bit is clear, that address stays fixed for the whole transfer.
- R7: When control bit 2 is set, stepping addresses move downward instead of upward.
- R8: A count of zero makes no memory access. The done flag is set two clock edges after the edge that writes the control word, and busy is high between those two edges.
- R9: On completion, control bit 31 of the channel clears and its done flag sets. Writing a 1 to a done bit in the status word clears that flag and leaves the other flags unchanged.
- R10: When several channels are enabled while the engine is busy, the lowest-numbered waiting channel is served next.
- R11: A read or write request held off by a low ready keeps its address, size and data unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register slot number |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the slot on reg_addr (combinational) |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_addr | output | 64 | Read byte address |
| rd_size | output | 2 | Read size code (2^code bytes) |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_ready | output | 1 | Engine can take read data |
| rd_resp_data | input | 64 | Read data, little-endian |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 64 | Write byte address |
| wr_size | output | 2 | Write size code (2^code bytes) |
| wr_data | output | 64 | Write data, element in the low bytes |

## Verification
Register writes take effect at the edge that samples `reg_wr`. Reads are combinational, so the bench samples them one nanosecond after a falling edge.

The zero-count case is the only path with a fixed delay. The first edge after the control write moves the engine to busy, and the second edge raises done. The bench samples the status word after each of those two edges.

Data transfers depend on the memory model's ready and response timing. For those, the bench polls the done flag at falling edges, with a bounded wait, and then compares the whole model memory and the beat counts against a reference copy it updates element by element. The priority case watches which done flags appear first after a long, back-pressured transfer.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 64;
  localparam int DATA_W   = 64;
  localparam int CNT_W    = 16;
  localparam int SLOTS_CH = 8;

  // slot index inside a channel block
  localparam logic [2:0] SL_CTRL = 3'd0;
  localparam logic [2:0] SL_CNT  = 3'd1;
  localparam logic [2:0] SL_SRCH = 3'd2;
  localparam logic [2:0] SL_SRCL = 3'd3;
  localparam logic [2:0] SL_DSTH = 3'd4;
  localparam logic [2:0] SL_DSTL = 3'd5;
  localparam logic [2:0] SL_SGH  = 3'd6;
  localparam logic [2:0] SL_SGL  = 3'd7;

  // control word fields
  localparam int CB_EN   = 31;
  localparam int CB_WLO  = 25;
  localparam int CB_DINC = 24;
  localparam int CB_SINC = 23;
  localparam int CB_DEC  = 2;
  localparam int ST_BUSY = 8;

  typedef enum logic [2:0] {MV_IDLE, MV_RD, MV_RWAIT, MV_WR, MV_FIN} mv_state_e;
endpackage

// File: rtl/dma4_pick.sv
module dma4_pick #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  output logic              any,
  output logic [CH_W-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = CH_W'(i);
      end
    end
  end

  // R10: chosen channel is requesting and no lower channel is waiting
  a_r10_granted_requests: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[idx]);
  a_r10_none_lower: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((req & ((NUM_CH'(1) << idx) - NUM_CH'(1))) == '0));
endmodule

// File: rtl/dma4_regs.sv
module dma4_regs
  import dma4_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int STAT_SLOT = NUM_CH * SLOTS_CH,
  localparam int AW = $clog2(STAT_SLOT + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [AW-1:0]                  addr,
  input  logic [REG_W-1:0]               wdata,
  output logic [REG_W-1:0]               rdata,
  input  logic                           busy,
  input  logic                           fin,
  input  logic [CH_W-1:0]                fin_ch,
  output logic [NUM_CH-1:0][REG_W-1:0]   ctrl_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cnt_o,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  src_o,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  dst_o
);
  logic [REG_W-1:0]  ctrl_r [NUM_CH];
  logic [REG_W-1:0]  cnt_r  [NUM_CH];
  logic [ADDR_W-1:0] src_r  [NUM_CH];
  logic [ADDR_W-1:0] dst_r  [NUM_CH];
  logic [ADDR_W-1:0] sg_r   [NUM_CH];
  logic [NUM_CH-1:0] done_q;

  logic [AW-4:0] blk;
  logic          stat_hit;
  assign blk      = addr[AW-1:3];
  assign stat_hit = (addr == AW'(STAT_SLOT));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr && (blk == (AW-3)'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_r[c] <= '0;
        cnt_r[c]  <= '0;
        src_r[c]  <= '0;
        dst_r[c]  <= '0;
        sg_r[c]   <= '0;
      end else begin
        if (hit) begin
          case (addr[2:0])
            SL_CTRL: ctrl_r[c] <= wdata;
            SL_CNT:  cnt_r[c]  <= wdata;
            SL_SRCH: src_r[c][63:32] <= wdata;
            SL_SRCL: src_r[c][31:0]  <= wdata;
            SL_DSTH: dst_r[c][63:32] <= wdata;
            SL_DSTL: dst_r[c][31:0]  <= wdata;
            SL_SGH:  sg_r[c][63:32]  <= wdata;
            default: sg_r[c][31:0]   <= wdata;
          endcase
        end
        // completion overrides a same-cycle control write
        if (fin && fin_ch == CH_W'(c)) ctrl_r[c][CB_EN] <= 1'b0;
      end
    end

    assign ctrl_o[c] = ctrl_r[c];
    assign cnt_o[c]  = cnt_r[c][CNT_W-1:0];
    assign src_o[c]  = src_r[c];
    assign dst_o[c]  = dst_r[c];

    // R3: writing one half keeps the other
    a_r3_src_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && addr[2:0] == SL_SRCH) |=> (src_r[c][31:0] == $past(src_r[c][31:0])));
    a_r3_dst_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && addr[2:0] == SL_DSTL) |=> (dst_r[c][63:32] == $past(dst_r[c][63:32])));
  end

  logic [NUM_CH-1:0] clr_m, set_m;
  assign clr_m = (wr && stat_hit) ? wdata[NUM_CH-1:0] : '0;
  assign set_m = fin ? (NUM_CH'(1) << fin_ch) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= '0;
    else        done_q <= (done_q & ~clr_m) | set_m;
  end

  always_comb begin
    rdata = '0;
    if (stat_hit) begin
      rdata[NUM_CH-1:0] = done_q;
      rdata[ST_BUSY]    = busy;
    end else if (int'(blk) < NUM_CH) begin
      case (addr[2:0])
        SL_CTRL: rdata = ctrl_r[addr[3 +: CH_W]];
        SL_CNT:  rdata = cnt_r[addr[3 +: CH_W]];
        SL_SRCH: rdata = src_r[addr[3 +: CH_W]][63:32];
        SL_SRCL: rdata = src_r[addr[3 +: CH_W]][31:0];
        SL_DSTH: rdata = dst_r[addr[3 +: CH_W]][63:32];
        SL_DSTL: rdata = dst_r[addr[3 +: CH_W]][31:0];
        SL_SGH:  rdata = sg_r[addr[3 +: CH_W]][63:32];
        default: rdata = sg_r[addr[3 +: CH_W]][31:0];
      endcase
    end
  end

  // R9: completion drops enable and raises done for that channel
  a_r9_finish_effect: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (!ctrl_r[$past(fin_ch)][CB_EN] && done_q[$past(fin_ch)]));
endmodule

// File: rtl/dma4_mover.sv
module dma4_mover
  import dma4_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   start_ch,
  input  logic [1:0]        cfg_code,
  input  logic              cfg_sinc,
  input  logic              cfg_dinc,
  input  logic              cfg_dec,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_size,
  input  logic              rd_resp_valid,
  output logic              rd_resp_ready,
  input  logic [DATA_W-1:0] rd_resp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        wr_size,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              fin,
  output logic [CH_W-1:0]   fin_ch
);
  mv_state_e         st;
  logic [CH_W-1:0]   ch_q;
  logic [1:0]        code_q;
  logic              sinc_q, dinc_q, dec_q;
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] step;
  logic [DATA_W-1:0] keep;

  assign step = ADDR_W'(1) << code_q;
  assign keep = ~({DATA_W{1'b1}} << (8 << code_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= MV_IDLE;
      ch_q <= '0; code_q <= '0;
      sinc_q <= 1'b0; dinc_q <= 1'b0; dec_q <= 1'b0;
      left_q <= '0; src_q <= '0; dst_q <= '0; data_q <= '0;
    end else begin
      case (st)
        MV_IDLE: if (start) begin
          ch_q <= start_ch; code_q <= cfg_code;
          sinc_q <= cfg_sinc; dinc_q <= cfg_dinc; dec_q <= cfg_dec;
          left_q <= cfg_cnt; src_q <= cfg_src; dst_q <= cfg_dst;
          st <= (cfg_cnt == '0) ? MV_FIN : MV_RD;
        end
        MV_RD: if (rd_req_ready) st <= MV_RWAIT;
        MV_RWAIT: if (rd_resp_valid) begin
          data_q <= rd_resp_data & keep;
          st <= MV_WR;
        end
        MV_WR: if (wr_ready) begin
          if (sinc_q) src_q <= dec_q ? src_q - step : src_q + step;
          if (dinc_q) dst_q <= dec_q ? dst_q - step : dst_q + step;
          left_q <= left_q - CNT_W'(1);
          st <= (left_q == CNT_W'(1)) ? MV_FIN : MV_RD;
        end
        default: st <= MV_IDLE;
      endcase
    end
  end

  assign rd_req_valid  = (st == MV_RD);
  assign rd_addr       = src_q;
  assign rd_size       = code_q;
  assign rd_resp_ready = (st == MV_RWAIT);
  assign wr_valid      = (st == MV_WR);
  assign wr_addr       = dst_q;
  assign wr_size       = code_q;
  assign wr_data       = data_q;
  assign busy          = (st != MV_IDLE);
  assign fin           = (st == MV_FIN);
  assign fin_ch        = ch_q;

  // R11: stalled requests hold steady
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr) && $stable(rd_size)));
  a_r11_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R6: a non-stepping source is unchanged across an element
  a_r6_src_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !sinc_q) |=> $stable(rd_addr));
  // R8: zero count goes straight to completion
  a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cfg_cnt == '0) |=> (fin && !rd_req_valid));
  // R5: bytes above the element are zero on the write bus
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_data & ~keep) == '0));
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW = $clog2(NUM_CH * SLOTS_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_size,
  input  logic              rd_resp_valid,
  output logic              rd_resp_ready,
  input  logic [DATA_W-1:0] rd_resp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        wr_size,
  output logic [DATA_W-1:0] wr_data
);
  logic [NUM_CH-1:0][REG_W-1:0]  ctrl_a;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_a;
  logic [NUM_CH-1:0][ADDR_W-1:0] src_a, dst_a;
  logic [NUM_CH-1:0]             req;
  logic                          pick_any, busy, fin;
  logic [CH_W-1:0]               pick_idx, fin_ch;
  logic [REG_W-1:0]              sel_ctrl;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_req
    assign req[c] = ctrl_a[c][CB_EN];
  end
  assign sel_ctrl = ctrl_a[pick_idx];

  dma4_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk, .rst_n, .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .busy, .fin, .fin_ch, .ctrl_o(ctrl_a), .cnt_o(cnt_a), .src_o(src_a), .dst_o(dst_a)
  );

  dma4_pick #(.NUM_CH(NUM_CH)) u_pick (
    .clk, .rst_n, .req, .any(pick_any), .idx(pick_idx)
  );

  dma4_mover #(.NUM_CH(NUM_CH)) u_mover (
    .clk, .rst_n, .start(pick_any), .start_ch(pick_idx),
    .cfg_code(sel_ctrl[CB_WLO +: 2]), .cfg_sinc(sel_ctrl[CB_SINC]),
    .cfg_dinc(sel_ctrl[CB_DINC]), .cfg_dec(sel_ctrl[CB_DEC]),
    .cfg_cnt(cnt_a[pick_idx]), .cfg_src(src_a[pick_idx]), .cfg_dst(dst_a[pick_idx]),
    .rd_req_valid, .rd_req_ready, .rd_addr, .rd_size,
    .rd_resp_valid, .rd_resp_ready, .rd_resp_data,
    .wr_valid, .wr_ready, .wr_addr, .wr_size, .wr_data,
    .busy, .fin, .fin_ch
  );
endmodule

// File: tb/dma4_engine_test.sv
`timescale 1ns/1ps
module dma4_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rd_req_valid, rd_resp_ready, wr_valid;
  logic        rd_req_ready = 1'b1, wr_ready = 1'b1, rd_resp_valid = 1'b0;
  logic [63:0] rd_addr, wr_addr, wr_data;
  logic [63:0] rd_resp_data = '0;
  logic [1:0]  rd_size, wr_size;

  always #2.5 clk = ~clk;

  dma4_engine uut (.*);

  // memory model
  logic [7:0] mem [256];
  logic [7:0] expm [256];
  logic       init_req = 1'b0, bp = 1'b0;
  int         seed = 0, rd_beats = 0, wr_beats = 0;

  function automatic logic [7:0] pat(int i, int s);
    return 8'(i * 13 + s * 29 + 5);
  endfunction

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i, seed);
      rd_beats <= 0; wr_beats <= 0;
    end else begin
      if (rd_resp_valid && rd_resp_ready) rd_resp_valid <= 1'b0;
      if (rd_req_valid && rd_req_ready) begin
        logic [63:0] t;
        for (int k = 0; k < 8; k++) t[8*k +: 8] = mem[8'(rd_addr[7:0] + 8'(k))];
        rd_resp_data <= t; rd_resp_valid <= 1'b1; rd_beats <= rd_beats + 1;
      end
      if (wr_valid && wr_ready) begin
        for (int k = 0; k < (1 << wr_size); k++) mem[8'(wr_addr[7:0] + 8'(k))] <= wr_data[8*k +: 8];
        wr_beats <= wr_beats + 1;
      end
    end
    rd_req_ready <= bp ? ~rd_req_ready : 1'b1;
    wr_ready     <= bp ? ~wr_ready : 1'b1;
  end

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input int slot, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 6'(slot); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input int slot, output logic [31:0] d);
    @(negedge clk); reg_addr = 6'(slot); #1 d = reg_rdata;
  endtask

  task automatic init_mem(input int s);
    seed = s;
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
    for (int i = 0; i < 256; i++) expm[i] = pat(i, s);
  endtask

  task automatic wait_done(input int ch, input string req);
    logic [31:0] st;
    bit got = 1'b0;
    for (int n = 0; n < 3000 && !got; n++) begin
      rreg(32, st);
      got = st[ch];
    end
    chk(got, req, 64'(st), 64'(1 << ch));
  endtask

  function automatic logic [31:0] ctrl_word(int code, bit si, bit di, bit dc);
    return 32'h8000_0000 | (32'(code) << 25) | (32'(di) << 24) | (32'(si) << 23) | (32'(dc) << 2);
  endfunction

  // {ch, code, sinc, dinc, dec, bp, count, src, dst}
  localparam logic [31:0] VECS [0:5] = '{
    {2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd5, 8'h10, 8'h80},
    {2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd4, 8'h20, 8'h90},
    {2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3, 8'h30, 8'hA0},
    {2'd3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3, 8'h40, 8'hB0},
    {2'd0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8'd3, 8'h5C, 8'hDC},
    {2'd1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'd2, 8'h08, 8'hC0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset values
    for (int s = 0; s <= 32; s++) begin
      rreg(s, d);
      chk(d == 32'd0, $sformatf("R1 slot %0d", s), 64'(d), 64'd0);
    end

    // main vector walk: R4 R5 R6 R7 R9 R11
    for (int v = 0; v < 6; v++) begin
      int ch, code, cnt, sz, sa, da;
      bit si, di, dc;
      int bad;
      {ch, code} = {30'(VECS[v][31:30]), 30'(VECS[v][29:28])};
      ch = int'(VECS[v][31:30]); code = int'(VECS[v][29:28]);
      si = VECS[v][27]; di = VECS[v][26]; dc = VECS[v][25];
      cnt = int'(VECS[v][23:16]); sa = int'(VECS[v][15:8]); da = int'(VECS[v][7:0]);
      sz = 1 << code;
      init_mem(v + 1);
      bp = VECS[v][24];
      wreg(ch * 8 + 1, 32'hABCD_0000 | 32'(cnt));
      wreg(ch * 8 + 2, 32'd0); wreg(ch * 8 + 3, 32'(sa));
      wreg(ch * 8 + 4, 32'd0); wreg(ch * 8 + 5, 32'(da));
      wreg(ch * 8 + 0, ctrl_word(code, si, di, dc));
      for (int e = 0; e < cnt; e++) begin
        for (int k = 0; k < sz; k++) expm[8'(da + k)] = expm[8'(sa + k)];
        if (si) sa = dc ? sa - sz : sa + sz;
        if (di) da = dc ? da - sz : da + sz;
      end
      wait_done(ch, $sformatf("R9 vec %0d done", v));
      repeat (2) @(negedge clk);
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) bad++;
      chk(bad == 0, $sformatf("R5/R6/R7 vec %0d memory", v), 64'(bad), 64'd0);
      chk(rd_beats == cnt && wr_beats == cnt, $sformatf("R4 vec %0d beats", v),
          64'(wr_beats), 64'(cnt));
      rreg(ch * 8, d);
      chk(d[31] == 1'b0, $sformatf("R9 vec %0d enable cleared", v), 64'(d), 64'(d & 32'h7FFF_FFFF));
      wreg(32, 32'(1 << ch));
      bp = 1'b0;
    end

    // R2 / R3: readback and half writes
    wreg(2 * 8 + 2, 32'h1234_5678);
    wreg(2 * 8 + 3, 32'h9ABC_DEF0);
    wreg(2 * 8 + 2, 32'h0000_0055);
    rreg(2 * 8 + 3, d);
    chk(d == 32'h9ABC_DEF0, "R3 low half kept", 64'(d), 64'h9ABC_DEF0);
    rreg(2 * 8 + 2, d);
    chk(d == 32'h55, "R3 high half updated", 64'(d), 64'h55);
    wreg(1 * 8 + 6, 32'hCAFE_0001);
    wreg(1 * 8 + 7, 32'h0BAD_F00D);
    rreg(1 * 8 + 6, d); rreg(1 * 8 + 7, d2);
    chk({d, d2} == 64'hCAFE_0001_0BAD_F00D, "R2 descriptor pointer readback", {d, d2}, 64'hCAFE_0001_0BAD_F00D);
    rreg(1 * 8 + 1, d);
    chk(d == 32'hABCD_0002, "R2 count readback", 64'(d), 64'hABCD_0002);

    // R8: zero count timing
    init_mem(9);
    wreg(3 * 8 + 1, 32'hFFFF_0000);
    wreg(3 * 8 + 0, ctrl_word(0, 1, 1, 0));
    reg_addr = 6'd32;
    @(posedge clk); #1;
    chk(reg_rdata[3] == 1'b0 && reg_rdata[8] == 1'b1, "R8 after first edge", 64'(reg_rdata), 64'h100);
    @(posedge clk); #1;
    chk(reg_rdata[3] == 1'b1 && reg_rdata[8] == 1'b0, "R8 after second edge", 64'(reg_rdata), 64'h8);
    chk(rd_beats == 0 && wr_beats == 0, "R8 no memory access", 64'(rd_beats + wr_beats), 64'd0);

    // R9: write-one-to-clear leaves others
    wreg(1 * 8 + 1, 32'd0);
    wreg(1 * 8 + 0, ctrl_word(0, 0, 0, 0));
    repeat (3) @(negedge clk);
    wreg(32, 32'h8);
    rreg(32, d);
    chk(d[3:0] == 4'h2, "R9 done clear one flag", 64'(d), 64'h2);
    wreg(32, 32'hF);

    // R10: lowest waiting channel served first
    init_mem(11);
    bp = 1'b1;
    wreg(0 * 8 + 1, 32'd20); wreg(0 * 8 + 3, 32'h00); wreg(0 * 8 + 5, 32'h40);
    wreg(1 * 8 + 1, 32'd1);  wreg(1 * 8 + 3, 32'h80); wreg(1 * 8 + 5, 32'hE0);
    wreg(3 * 8 + 1, 32'd1);  wreg(3 * 8 + 3, 32'h90); wreg(3 * 8 + 5, 32'hF0);
    wreg(0 * 8 + 0, ctrl_word(0, 1, 1, 0));
    wreg(3 * 8 + 0, ctrl_word(0, 1, 1, 0));
    wreg(1 * 8 + 0, ctrl_word(0, 1, 1, 0));
    begin
      bit seen = 1'b0;
      for (int n = 0; n < 3000 && !seen; n++) begin
        rreg(32, d);
        if ((d & 32'hA) != 0) seen = 1'b1;
      end
      chk((d & 32'hA) == 32'h2, "R10 channel 1 before channel 3", 64'(d & 32'hA), 64'h2);
    end
    wait_done(3, "R10 channel 3 completes");
    chk(mem[8'hF0] == pat(32'h90, 11), "R10 channel 3 data", 64'(mem[8'hF0]), 64'(pat(32'h90, 11)));
    bp = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule